// File: doc/BRIEF.md
# Subcycle Pattern Timing Generator

This block produces one timing cycle as a run of subcycles. Each subcycle is one clock. The block keeps a small writable pattern memory with one 12-bit control word per subcycle, and the subcycle counter selects the word in use. The current word sets the levels of six pattern clock outputs. It can hold the subcycle until chosen condition inputs are true. It can let a marker from the sequencer through to a trigger output. It can also mark the subcycle that follows as the last one of the cycle, either always or only when the Ready input is true.

Software or a loader fills the memory through a simple write and read port while the block is idle. It then raises the run enable. Every completed cycle is reported by a one-clock end-of-cycle strobe, and the counter then starts again at subcycle 0. The length of a cycle therefore depends only on the stored end flags, the Ready input and any condition waits. The top memory address always closes the cycle.

Top module: `subcycle_timing_gen`

## Requirements
- R1: After reset the tick outputs read 0, the trigger and end-of-cycle outputs are low, the counter is at subcycle 0, and every memory word holds 12'hF00, so readback gives 16'hFF00.
- R2: A write stores memWrData[11:0] at memAddr on the clock edge. memRdData always shows the word at memAddr as {4'hF, word[11:0]}, with no clock delay.
- R3: While running, tick equals bits 5..0 of the current subcycle's word. A cycle starts at subcycle 0, and each completed subcycle moves the counter up by one.
- R4: trig is high exactly when runEn is high, marker is high, and bit 8 of the current word is 0. Bit 8 is an active-low enable.
- R5: When bit 6 is set in a completed subcycle, the next subcycle is the last of the cycle. endCycle is high while that last subcycle completes, and the counter returns to 0 on the following clock.
- R6: Bit 7 acts like bit 6, but only if ready is high on the clock where the subcycle carrying bit 7 completes. With ready low, the cycle goes on.
- R7: The subcycle at address DEPTH-1 is always the last of its cycle, even when no end flag was seen.
- R8: Bits 11, 10 and 9 are active-low waits on cond[2], cond[1] and cond[0]. While any enabled condition is low, the counter, tick and trig hold their values. Conditions whose bit is 1 have no effect.
- R9: endCycle is high only in a clock where the last subcycle actually completes. It stays low while that subcycle is waiting on a condition.
- R10: While runEn is low, tick is 0 and trig and endCycle are low. The counter is forced to 0, so the next run starts at subcycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| memAddr | input | AW | Pattern memory address for write and readback |
| memWrEn | input | 1 | Write strobe for the pattern memory |
| memWrData | input | 12 | Control word to store |
| memRdData | output | 16 | Word at memAddr, upper four bits read as 1 |
| runEn | input | 1 | Run enable |
| ready | input | 1 | Ready input that qualifies bit 7 |
| cond | input | 3 | Condition inputs COND2..COND0 |
| marker | input | 1 | Marker flag from the sequencer for this cycle |
| tick | output | 6 | Pattern clock levels of the current subcycle |
| trig | output | 1 | Marker-gated trigger |
| endCycle | output | 1 | High while the last subcycle of a cycle completes |

## Verification
The bench builds the block with DEPTH set to 8. With that depth, a pattern with no end flags reaches the top address and wraps within a short run. The same short memory also allows an unconditional end, a Ready-qualified end taken and then not taken, and condition stalls in the middle and at the last subcycle, each in a few dozen clocks. Each word's tick field is loaded with its own address, so the tick outputs show which subcycle is in use. Every expected output triple in the scoreboard can then be written down from the requirements.

// File: rtl/subcycle_timing_pkg.sv
package subcycle_timing_pkg;

  localparam int WORD_W      = 12;
  localparam int NUM_TICK    = 6;
  localparam int NUM_COND    = 3;
  localparam int RD_W        = 16;

  localparam int TICK_LSB    = 0;
  localparam int END_BIT     = 6;
  localparam int END_RDY_BIT = 7;
  localparam int TRIG_N_BIT  = 8;
  localparam int COND_LSB    = 9;

  localparam logic [WORD_W-1:0] WORD_RESET = 12'hF00;

  typedef struct packed {
    logic advance;
    logic restart;
  } seqStrobe_t;

endpackage

// File: rtl/subcycle_timing_dp.sv
module subcycle_timing_dp
  import subcycle_timing_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [AW-1:0]     memAddr,
  input  logic              memWrEn,
  input  logic [WORD_W-1:0] memWrData,
  output logic [RD_W-1:0]   memRdData,
  input  logic              runEn,
  input  logic              marker,
  input  seqStrobe_t        strobe,
  output logic [WORD_W-1:0] curWord,
  output logic              atTop,
  output logic [AW-1:0]     subIdx,
  output logic [NUM_TICK-1:0] tick,
  output logic              trig
);

  localparam logic [AW-1:0] TOP_IDX = AW'(DEPTH - 1);
  localparam int PAD_W = RD_W - WORD_W;

  logic [WORD_W-1:0] patMem [DEPTH];
  logic [AW-1:0]     subCnt;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        patMem[g] <= WORD_RESET;
      end else if (memWrEn && (memAddr == AW'(g))) begin
        patMem[g] <= memWrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subCnt <= '0;
    end else if (strobe.restart) begin
      subCnt <= '0;
    end else if (strobe.advance) begin
      subCnt <= subCnt + AW'(1);
    end
  end

  always_comb begin
    curWord   = patMem[subCnt];
    atTop     = (subCnt == TOP_IDX);
    subIdx    = subCnt;
    memRdData = {{PAD_W{1'b1}}, patMem[memAddr]};
    tick      = runEn ? curWord[TICK_LSB +: NUM_TICK] : '0;
    trig      = runEn & marker & ~curWord[TRIG_N_BIT];
  end

  // R4
  trig_marker_chk: assert property (@(posedge clk) disable iff (!rstN)
    trig |-> (marker && runEn));

  // R1
  rdback_pad_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdData[RD_W-1 -: PAD_W] == {PAD_W{1'b1}});

endmodule

// File: rtl/subcycle_timing_ctrl.sv
module subcycle_timing_ctrl
  import subcycle_timing_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                runEn,
  input  logic                ready,
  input  logic [NUM_COND-1:0] cond,
  input  logic [WORD_W-1:0]   curWord,
  input  logic                atTop,
  output seqStrobe_t          strobe,
  output logic                stall,
  output logic                endCycle
);

  logic [NUM_COND-1:0] blocked;
  logic                lastPending;
  logic                isLast;
  logic                doneSub;
  logic                nextIsLast;

  for (genvar g = 0; g < NUM_COND; g++) begin : g_cond
    assign blocked[g] = ~curWord[COND_LSB + g] & ~cond[g];
  end

  always_comb begin
    stall          = runEn & (|blocked);
    doneSub        = runEn & ~stall;
    isLast         = lastPending | atTop;
    endCycle       = doneSub & isLast;
    nextIsLast     = curWord[END_BIT] | (curWord[END_RDY_BIT] & ready);
    strobe.advance = doneSub & ~isLast;
    strobe.restart = ~runEn | endCycle;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastPending <= 1'b0;
    end else if (strobe.restart) begin
      lastPending <= 1'b0;
    end else if (strobe.advance) begin
      lastPending <= nextIsLast;
    end
  end

  // R7
  top_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && atTop && !stall) |-> endCycle);

  // R9
  no_end_stalled_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> !endCycle);

endmodule

// File: rtl/subcycle_timing_gen.sv
module subcycle_timing_gen
  import subcycle_timing_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] memAddr,
  input  logic          memWrEn,
  input  logic [11:0]   memWrData,
  output logic [15:0]   memRdData,
  input  logic          runEn,
  input  logic          ready,
  input  logic [2:0]    cond,
  input  logic          marker,
  output logic [5:0]    tick,
  output logic          trig,
  output logic          endCycle
);

  seqStrobe_t        strobe;
  logic [WORD_W-1:0] curWord;
  logic              atTop;
  logic              stall;
  logic [AW-1:0]     subIdx;

  subcycle_timing_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .runEn    (runEn),
    .ready    (ready),
    .cond     (cond),
    .curWord  (curWord),
    .atTop    (atTop),
    .strobe   (strobe),
    .stall    (stall),
    .endCycle (endCycle)
  );

  subcycle_timing_dp #(.DEPTH(DEPTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .memAddr   (memAddr),
    .memWrEn   (memWrEn),
    .memWrData (memWrData),
    .memRdData (memRdData),
    .runEn     (runEn),
    .marker    (marker),
    .strobe    (strobe),
    .curWord   (curWord),
    .atTop     (atTop),
    .subIdx    (subIdx),
    .tick      (tick),
    .trig      (trig)
  );

  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    endCycle |=> (subIdx == '0));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> $stable(subIdx));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> (tick == '0 && !trig && !endCycle));

  // R10
  idle_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (subIdx == '0));

endmodule

// File: tb/subcycle_timing_gen_tb.sv
module subcycle_timing_gen_tb;

  localparam int DEPTH = 8;
  localparam int AW = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] memAddr = '0;
  logic          memWrEn = 1'b0;
  logic [11:0]   memWrData = '0;
  logic [15:0]   memRdData;
  logic          runEn = 1'b0;
  logic          ready = 1'b0;
  logic [2:0]    cond = '0;
  logic          marker = 1'b0;
  logic [5:0]    tick;
  logic          trig;
  logic          endCycle;

  int total = 0;
  int bad = 0;

  logic [7:0] expQ[$];
  string      tagQ[$];

  subcycle_timing_gen #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memWrEn(memWrEn),
    .memWrData(memWrData), .memRdData(memRdData), .runEn(runEn),
    .ready(ready), .cond(cond), .marker(marker), .tick(tick),
    .trig(trig), .endCycle(endCycle)
  );

  always #10 clk = ~clk;

  task automatic writeWord(input logic [AW-1:0] a, input logic [11:0] d);
    @(negedge clk);
    memAddr = a; memWrData = d; memWrEn = 1'b1;
    @(negedge clk);
    memWrEn = 1'b0;
  endtask

  task automatic checkRead(input logic [AW-1:0] a, input logic [15:0] e, input string tag);
    @(negedge clk);
    memAddr = a;
    #8;
    total++;
    if (memRdData !== e) begin
      bad++;
      $display("FAIL %s: memRdData=%h expected %h", tag, memRdData, e);
    end
  endtask

  task automatic cyc(input logic r, input logic rd, input logic [2:0] c, input logic mk,
                     input logic [5:0] t, input logic tg, input logic e, input string tag);
    @(negedge clk);
    runEn = r; ready = rd; cond = c; marker = mk;
    expQ.push_back({t, tg, e});
    tagQ.push_back(tag);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #8;
      if (expQ.size() > 0) begin
        logic [7:0] ex;
        string tg;
        ex = expQ.pop_front();
        tg = tagQ.pop_front();
        total++;
        if ({tick, trig, endCycle} !== ex) begin
          bad++;
          $display("FAIL %s: tick=%0d trig=%0b eoc=%0b expected tick=%0d trig=%0b eoc=%0b",
                   tg, tick, trig, endCycle, ex[7:2], ex[1], ex[0]);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not finish, got hung expected done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #8;
    total++;
    if ({tick, trig, endCycle} !== 8'h00) begin
      bad++;
      $display("FAIL R1: outputs=%h expected 00", {tick, trig, endCycle});
    end
    checkRead(3'd0, 16'hFF00, "R1");

    // Pattern: tick field = address, trigger enabled in subcycles 0 and 1 only
    for (int i = 0; i < DEPTH; i++)
      writeWord(AW'(i), ((i < 2) ? 12'hE00 : 12'hF00) | 12'(i));
    checkRead(3'd5, 16'hFF05, "R2");
    writeWord(3'd6, 12'hABC);
    checkRead(3'd6, 16'hFABC, "R2");
    writeWord(3'd6, 12'hF06);
    checkRead(3'd6, 16'hFF06, "R2");

    // marker low: no trigger; then stop mid-cycle
    cyc(1, 0, 3'b000, 0, 6'd0, 0, 0, "R4");
    cyc(1, 0, 3'b000, 0, 6'd1, 0, 0, "R4");
    cyc(1, 0, 3'b000, 0, 6'd2, 0, 0, "R3");
    cyc(0, 0, 3'b000, 1, 6'd0, 0, 0, "R10");
    // run to top address and wrap, marker high
    for (int k = 0; k < 10; k++)
      cyc(1, 0, 3'b000, 1, 6'(k % 8), (k % 8) < 2, (k % 8) == 7, "R3/R4/R7");
    cyc(0, 0, 3'b000, 1, 6'd0, 0, 0, "R10");

    // unconditional end flag on subcycle 2
    writeWord(3'd2, 12'hF42);
    for (int k = 0; k < 8; k++)
      cyc(1, 0, 3'b000, 1, 6'(k % 4), (k % 4) < 2, (k % 4) == 3, "R5");
    cyc(0, 0, 3'b000, 0, 6'd0, 0, 0, "R10");

    // Ready-qualified end flag on subcycle 2
    writeWord(3'd2, 12'hF82);
    cyc(1, 1, 3'b000, 0, 6'd0, 0, 0, "R6");
    cyc(1, 1, 3'b000, 0, 6'd1, 0, 0, "R6");
    cyc(1, 1, 3'b000, 0, 6'd2, 0, 0, "R6");
    cyc(1, 1, 3'b000, 0, 6'd3, 0, 1, "R6");
    cyc(1, 1, 3'b000, 0, 6'd0, 0, 0, "R6");
    cyc(1, 1, 3'b000, 0, 6'd1, 0, 0, "R6");
    cyc(1, 0, 3'b000, 0, 6'd2, 0, 0, "R6");
    for (int k = 3; k < 8; k++)
      cyc(1, 1, 3'b000, 0, 6'(k), 0, k == 7, "R6");
    cyc(1, 1, 3'b000, 0, 6'd0, 0, 0, "R6");
    cyc(0, 0, 3'b000, 0, 6'd0, 0, 0, "R10");
    writeWord(3'd2, 12'hF02);

    // condition waits: subcycle 4 on cond[1], subcycle 7 on cond[2]
    writeWord(3'd4, 12'hB04);
    writeWord(3'd7, 12'h707);
    for (int k = 0; k < 4; k++)
      cyc(1, 0, 3'b000, 1, 6'(k), k < 2, 0, "R8");
    cyc(1, 0, 3'b000, 1, 6'd4, 0, 0, "R8");
    cyc(1, 0, 3'b000, 1, 6'd4, 0, 0, "R8");
    cyc(1, 0, 3'b101, 1, 6'd4, 0, 0, "R8");
    cyc(1, 0, 3'b010, 1, 6'd4, 0, 0, "R8");
    cyc(1, 0, 3'b000, 1, 6'd5, 0, 0, "R8");
    cyc(1, 0, 3'b000, 1, 6'd6, 0, 0, "R8");
    cyc(1, 0, 3'b000, 1, 6'd7, 0, 0, "R9");
    cyc(1, 0, 3'b011, 1, 6'd7, 0, 0, "R9");
    cyc(1, 0, 3'b100, 1, 6'd7, 0, 1, "R9");
    cyc(1, 0, 3'b000, 1, 6'd0, 1, 0, "R9");
    cyc(0, 0, 3'b000, 1, 6'd0, 0, 0, "R10");

    @(negedge clk);
    #9;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule